// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Receiver

This block receives asynchronous serial frames in which every character carries one extra address-marker bit. A marker of 1 tags the frame as a station address, and a marker of 0 tags it as a payload byte. Each bit is recovered by 16x oversampling driven from a fixed clock divider. The line is sampled at the middle of each bit period. A start edge that turns out to be a short glitch is rejected.

Software drives the block through a small register port. A control register holds receive enable, an address-wait bit and an interrupt enable. A status register holds the data-ready, overrun and framing-error flags, plus the live level of the serial line. A data register holds the last accepted byte. When software sets address-wait, the receiver skips payload frames until a frame marked as an address arrives. That frame is delivered, and the wait bit then drops by itself. Software compares the delivered byte with its own station number. After any reception error the receiver stays silent until software clears the error. After a framing error, software reads the line level to spot a break.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, control (address 0) reads 0, status (address 1) reads only the line bit (bit 3) as 1, data (address 2) reads 0, and `irq` is low.
- R2: With receive enable (control bit 0) set, a frame is accepted as follows: a low start bit, 8 data bits LSB first, one marker bit, and a high stop bit. The byte appears at address 2, and data-ready (status bit 0) becomes 1.
- R3: `irq` is high exactly when data-ready is 1 and interrupt enable (control bit 2) is 1.
- R4: Writing status with bit 0 = 0 clears data-ready. Writing a 1 to any flag bit leaves that flag unchanged.
- R5: While address-wait (control bit 1) is 1, a frame with marker 0 is dropped. It changes no flag and no data.
- R6: While address-wait is 1, a frame with marker 1 loads the data register, sets data-ready and clears address-wait.
- R7: A good frame that would load while data-ready is still 1 sets overrun (status bit 1) and keeps the old data.
- R8: A frame whose stop bit samples low sets framing error (status bit 2) and leaves data and data-ready unchanged.
- R9: While overrun or framing error is 1, no frame is received. Writing 0 to a flag bit clears that flag, and reception resumes once both are clear.
- R10: Status bit 3 follows the current serial input level, two clocks late. A held-low line after a framing error therefore reads 0.
- R11: Clearing receive enable stops reception, and a frame in progress at that moment is abandoned.
- R12: A low pulse shorter than half a bit period that is high again at the start-bit midpoint is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input, idle high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Receive interrupt request level |

## Verification
The assertions check the following on every cycle:
- what a completed frame does to the flags: a drop in address-wait mode, a load that clears the wait bit, an overrun that keeps the old data, and a framing error;
- that the data register never changes while an error flag is set;
- that data-ready only rises right after a completed frame.

Only the bench scenarios can show the rest, because these depend on real serial waveforms and on software register sequences:
- correct bit order and midpoint sampling;
- rejection of a start glitch;
- the abandoned frame when enable is cleared mid-frame;
- the break readback of the line level;
- that clearing only one of the two error flags keeps the receiver blocked.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // control bit positions
  localparam int CTRL_EN  = 0;
  localparam int CTRL_IDW = 1;
  localparam int CTRL_IE  = 2;

  // status bit positions
  localparam int ST_RDY  = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FER  = 2;
  localparam int ST_LINE = 3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_MARK,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/mpu_rst_sync.sv
module mpu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/mpu_line_sync.sv
module mpu_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mpu_tick_gen.sv
module mpu_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == CNT_LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == CNT_LAST);
    end
  endgenerate

endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mark_o,
  output logic              stop_ok_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              mark_q, mark_d;
  logic              stop_q, stop_d;
  logic              done_q, done_d;
  logic              bit_end;

  assign bit_end = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    mark_d  = mark_q;
    stop_d  = stop_q;
    done_d  = 1'b0;

    if (!run_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!line_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_d = '0;
            idx_d = '0;
            if (!line_i) state_d = RX_DATA;
            else         state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_d = '0;
            if (DATA_W > 1) shf_d = {line_i, shf_q[DATA_W-1:1]};
            else            shf_d = line_i;
            if (idx_q == IDX_LAST) state_d = RX_MARK;
            else                   idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_MARK: begin
          if (bit_end) begin
            cnt_d   = '0;
            mark_d  = line_i;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_d   = '0;
            stop_d  = line_i;
            done_d  = 1'b1;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = RX_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      mark_q  <= 1'b0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      mark_q  <= mark_d;
      stop_q  <= stop_d;
      done_q  <= done_d;
    end
  end

  assign done_o    = done_q;
  assign data_o    = shf_q;
  assign mark_o    = mark_q;
  assign stop_ok_o = stop_q;

endmodule

// File: rtl/mpu_rx_regs.sv
module mpu_rx_regs
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] fdata_i,
  input  logic              fmark_i,
  input  logic              fstop_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              run_o,
  output logic              en_o,
  output logic              idw_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic [DATA_W-1:0] data_o
);

  logic              en_q, en_d;
  logic              idw_q, idw_d;
  logic              ie_q, ie_d;
  logic              rdy_q, rdy_d;
  logic              ovr_q, ovr_d;
  logic              fer_q, fer_d;
  logic [DATA_W-1:0] data_q;

  logic wr_ctrl, wr_stat;
  logic accept, ev_fer, ev_drop, ev_ovr, ev_load;
  logic unused_wdata;

  assign unused_wdata = &{1'b0, wdata_i[DATA_W-1:3]};

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);

  // frame outcome classification
  assign accept  = done_i && en_q && !ovr_q && !fer_q;
  assign ev_fer  = accept && !fstop_i;
  assign ev_drop = accept && fstop_i && idw_q && !fmark_i;
  assign ev_ovr  = accept && fstop_i && !ev_drop && rdy_q;
  assign ev_load = accept && fstop_i && !ev_drop && !rdy_q;

  always_comb begin
    en_d  = en_q;
    ie_d  = ie_q;
    idw_d = idw_q;
    if (ev_load && fmark_i) idw_d = 1'b0;
    if (wr_ctrl) begin
      en_d  = wdata_i[CTRL_EN];
      idw_d = wdata_i[CTRL_IDW];
      ie_d  = wdata_i[CTRL_IE];
    end

    rdy_d = rdy_q;
    ovr_d = ovr_q;
    fer_d = fer_q;
    if (wr_stat) begin
      if (!wdata_i[ST_RDY]) rdy_d = 1'b0;
      if (!wdata_i[ST_OVR]) ovr_d = 1'b0;
      if (!wdata_i[ST_FER]) fer_d = 1'b0;
    end
    if (ev_load) rdy_d = 1'b1;
    if (ev_ovr)  ovr_d = 1'b1;
    if (ev_fer)  fer_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idw_q <= 1'b0;
      ie_q  <= 1'b0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      fer_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      idw_q <= idw_d;
      ie_q  <= ie_d;
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      fer_q <= fer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (ev_load) begin
      data_q <= fdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]  = en_q;
        rdata_o[CTRL_IDW] = idw_q;
        rdata_o[CTRL_IE]  = ie_q;
      end
      ADDR_STAT: begin
        rdata_o[ST_RDY]  = rdy_q;
        rdata_o[ST_OVR]  = ovr_q;
        rdata_o[ST_FER]  = fer_q;
        rdata_o[ST_LINE] = line_i;
      end
      ADDR_DATA: rdata_o = data_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o  = rdy_q && ie_q;
  assign run_o  = en_q && !ovr_q && !fer_q;
  assign en_o   = en_q;
  assign idw_o  = idw_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign fer_o  = fer_q;
  assign data_o = data_q;

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic              rst_n_s;
  logic              line_s;
  logic              tick;
  logic              run;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_mark;
  logic              frm_stop;
  logic              st_en, st_idw, st_rdy, st_ovr, st_fer;
  logic [DATA_W-1:0] st_data;

  mpu_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  mpu_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (rxd),
    .q_o   (line_s)
  );

  mpu_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_o (tick)
  );

  mpu_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_i     (run),
    .tick_i    (tick),
    .line_i    (line_s),
    .done_o    (frm_done),
    .data_o    (frm_data),
    .mark_o    (frm_mark),
    .stop_ok_o (frm_stop)
  );

  mpu_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr_i  (reg_addr),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata),
    .done_i  (frm_done),
    .fdata_i (frm_data),
    .fmark_i (frm_mark),
    .fstop_i (frm_stop),
    .line_i  (line_s),
    .rdata_o (reg_rdata),
    .irq_o   (irq),
    .run_o   (run),
    .en_o    (st_en),
    .idw_o   (st_idw),
    .rdy_o   (st_rdy),
    .ovr_o   (st_ovr),
    .fer_o   (st_fer),
    .data_o  (st_data)
  );

endmodule

// File: rtl/mpu_rx_checker.sv
module mpu_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              done,
  input logic              mark,
  input logic              stop,
  input logic              en,
  input logic              idw,
  input logic              rdy,
  input logic              ovr,
  input logic              fer,
  input logic [DATA_W-1:0] data
);

  // R2: data-ready only rises right after a completed frame
  assert_ready_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(done));

  // R5: payload frame in address-wait mode leaves flags and data alone
  assert_drop_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop && idw && !mark && !wr) |=> ($stable(rdy) && $stable(ovr) && $stable(data)));

  // R6: address frame in wait mode is delivered and ends the wait
  assert_addr_delivers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && !ovr && !fer && stop && idw && mark && !rdy && !wr) |=> (rdy && !idw));

  // R7: good frame over unread data raises overrun and keeps the old byte
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && !ovr && !fer && stop && rdy && !(idw && !mark)) |=> (ovr && $stable(data)));

  // R8: low stop sample raises framing error
  assert_bad_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && !ovr && !fer && !stop) |=> (fer && $stable(data)));

  // R9: nothing is loaded while an error flag is set
  assert_error_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr || fer) |=> $stable(data));

endmodule

bind mp_uart_rx mpu_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .wr    (reg_wr),
  .done  (frm_done),
  .mark  (frm_mark),
  .stop  (frm_stop),
  .en    (st_en),
  .idw   (st_idw),
  .rdy   (st_rdy),
  .ovr   (st_ovr),
  .fer   (st_fer),
  .data  (st_data)
);

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;

  localparam int TICK_DIV = 4;
  localparam int OSR      = 16;
  localparam int BITC     = TICK_DIV * OSR;

  logic       clk;
  logic       rst_n;
  logic       rxd;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk;
  int n_bad;
  bit done_flag;

  // behavioural reference state
  bit       m_valid;
  bit       m_en, m_idw, m_ie, m_rdy, m_ovr, m_fer;
  bit [7:0] m_data;

  mp_uart_rx #(.DATA_W(8), .OSR(OSR), .TICK_DIV(TICK_DIV), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R3: interrupt level compared with the model on every clock
  always @(negedge clk) begin
    if (m_valid) begin
      n_chk++;
      if (irq !== (m_rdy & m_ie)) begin
        n_bad++;
        $display("FAIL R3 irq actual=%0b expected=%0b", irq, m_rdy & m_ie);
      end
    end
  end

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    #1;
    if (a == 2'd0) begin
      m_en = d[0]; m_idw = d[1]; m_ie = d[2];
    end else if (a == 2'd1) begin
      if (!d[0]) m_rdy = 1'b0;
      if (!d[1]) m_ovr = 1'b0;
      if (!d[2]) m_fer = 1'b0;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic void model_frame(input bit [7:0] b, input bit mk, input bit stp);
    if (!m_en || m_ovr || m_fer) return;
    if (!stp) begin m_fer = 1'b1; return; end
    if (m_idw && !mk) return;
    if (m_rdy) begin m_ovr = 1'b1; return; end
    m_data = b;
    m_rdy  = 1'b1;
    m_idw  = 1'b0;
  endfunction

  task automatic line_for(input logic lvl, input int bits);
    rxd = lvl;
    repeat (bits * BITC) @(negedge clk);
  endtask

  task automatic send(input bit [7:0] b, input bit mk, input bit stp);
    m_valid = 1'b0;
    @(negedge clk);
    line_for(1'b0, 1);
    for (int i = 0; i < 8; i++) line_for(b[i], 1);
    line_for(mk, 1);
    line_for(stp, 1);
    if (stp) line_for(1'b1, 2);
    else     line_for(1'b0, 2);
    model_frame(b, mk, stp);
    m_valid = 1'b1;
  endtask

  task automatic chk_stat(input string tag);
    logic [7:0] v;
    rd(2'd1, v);
    check(tag, v, {4'b0, rxd, m_fer, m_ovr, m_rdy});
  endtask

  task automatic chk_data(input string tag);
    logic [7:0] v;
    rd(2'd2, v);
    check(tag, v, m_data);
  endtask

  task automatic chk_ctrl(input string tag);
    logic [7:0] v;
    rd(2'd0, v);
    check(tag, v, {5'b0, m_ie, m_idw, m_en});
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 0;
    m_valid = 0; m_en = 0; m_idw = 0; m_ie = 0;
    m_rdy = 0; m_ovr = 0; m_fer = 0; m_data = 8'h00;
    rxd = 1'b1; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_valid = 1'b1;

    // R1: reset values
    chk_ctrl("R1 ctrl after reset");
    chk_stat("R1 status after reset");
    chk_data("R1 data after reset");
    check("R1 irq after reset", irq, 0);

    // R2 / R3: plain reception, interrupt gated by enable
    wr(2'd0, 8'h01);
    send(8'hA5, 1'b0, 1'b1);
    chk_stat("R2 ready after frame");
    chk_data("R2 byte A5 LSB first");
    check("R3 irq masked", irq, 0);
    wr(2'd0, 8'h05);
    check("R3 irq raised", irq, 1);

    // R4: write-one keeps, write-zero clears
    wr(2'd1, 8'hFF);
    chk_stat("R4 write ones keeps ready");
    wr(2'd1, 8'hFE);
    chk_stat("R4 ready cleared");
    check("R4 irq dropped", irq, 0);

    // R7: overrun keeps the first byte
    send(8'h3C, 1'b0, 1'b1);
    send(8'hC3, 1'b0, 1'b1);
    chk_stat("R7 overrun set");
    chk_data("R7 old byte kept");

    // R9: overrun alone still blocks
    wr(2'd1, 8'hFE);
    send(8'h77, 1'b0, 1'b1);
    chk_stat("R9 blocked by overrun");
    chk_data("R9 no load while blocked");
    wr(2'd1, 8'hFD);
    send(8'h77, 1'b0, 1'b1);
    chk_stat("R9 resumed after clear");
    chk_data("R9 byte 77 after resume");
    wr(2'd1, 8'hFE);

    // R5 / R6: address-wait mode
    wr(2'd0, 8'h07);
    send(8'h55, 1'b0, 1'b1);
    chk_stat("R5 payload dropped");
    chk_ctrl("R5 wait still set");
    send(8'hA3, 1'b1, 1'b1);
    chk_stat("R6 address frame ready");
    chk_data("R6 address byte");
    chk_ctrl("R6 wait cleared by hardware");
    wr(2'd1, 8'hFE);
    send(8'h3C, 1'b0, 1'b1);
    chk_data("R6 payload accepted after match");
    wr(2'd1, 8'hFE);

    // R12: start glitch rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    chk_stat("R12 glitch ignored");
    send(8'h81, 1'b0, 1'b1);
    chk_data("R12 next frame intact");
    wr(2'd1, 8'hFE);

    // R8 / R10: break produces framing error, line readback
    send(8'h00, 1'b0, 1'b0);
    chk_stat("R8 R10 framing error and low line");
    chk_data("R8 data unchanged");
    line_for(1'b1, 2);
    chk_stat("R10 line back high");
    send(8'h42, 1'b0, 1'b1);
    chk_stat("R9 blocked by framing error");
    wr(2'd1, 8'hFB);
    send(8'h42, 1'b0, 1'b1);
    chk_data("R9 byte 42 after clear");
    wr(2'd1, 8'hFE);

    // R11: enable cleared mid-frame
    fork
      send(8'h99, 1'b0, 1'b1);
      begin
        repeat (4 * BITC) @(negedge clk);
        wr(2'd0, 8'h04);
      end
    join
    chk_stat("R11 abandoned frame");
    send(8'h66, 1'b0, 1'b1);
    chk_data("R11 disabled no load");
    wr(2'd0, 8'h05);
    send(8'h66, 1'b0, 1'b1);
    chk_stat("R11 re-enabled ready");
    chk_data("R11 byte 66");

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule